// File: doc/BRIEF.md
# Supply Fault Event Register

This block holds the sticky supply and fault event flags of a multi-port power controller. One-cycle event pulses from the oscillator monitor, the thermal monitor and the supply lockout monitors set bits in an 8-bit status register. Each bit stays set until software clears it. Software reaches the register through a simple read strobe with an 8-bit address.

The same register answers at two addresses. A plain read at 0x0A returns the contents and leaves them in place. A clear-on-read at 0x0B returns the contents and then empties the register. The block also drives three outputs. The first is a summary flag that feeds bit 7 of the global interrupt summary word. The second is an interrupt output, in which the oscillator-failure flag only counts while a detection channel is enabled. The third is a set of per-port power enables that are held off while the device is in reset.

The reset value depends on which supply crossed its lockout threshold last, so that software can see why the device restarted.

Top module: `supply_event_reg`

## Requirements
- R1: When reset is applied with `last_neg_i`=1 (negative supply came up last), the register holds 8'h21 after reset, which sets bit 5 (negative lockout) and bit 0 (negative undervoltage).
- R2: When reset is applied with `last_neg_i`=0 (logic supply came up last), the register holds 8'h14 after reset, which sets bit 4 (logic lockout) and bit 2 (logic undervoltage).
- R3: A 1 on bit n of `evt_i` in a cycle sets status bit n at that clock edge. The bit stays 1 through any number of later cycles until it is cleared by a clear-on-read or by reset. The bit map is: 7 oscillator failure, 6 thermal recovery, 5 negative lockout, 4 logic lockout, 3 auxiliary lockout, 2 logic undervoltage, 1 auxiliary undervoltage, 0 negative undervoltage.
- R4: A read strobe at address 0x0A gives `rd_valid_o`=1 on the next cycle. In that cycle `rd_data_o` equals the register contents from the strobe cycle, and the contents are left unchanged.
- R5: A read strobe at address 0x0B returns the contents with the same one-cycle timing as R4. After the strobe edge, the register holds only the events that arrived in the strobe cycle.
- R6: An event pulse that arrives in the same cycle as a clear-on-read leaves its bit set after the clear.
- R7: `supply_any_o` is 1 exactly when any status bit is set, and it lags the register by one cycle.
- R8: `irq_o` lags the register by one cycle. It is 1 when any of bits 6..0 is set. It is also 1 when bit 7 is set while at least one bit of `det_en_i` is 1. With bit 7 alone set and `det_en_i`=0, `irq_o` stays 0.
- R9: While `rst` is 1, every bit of `port_en_o` is 0. Outside reset, `port_en_o` follows `port_req_i` one cycle later.
- R10: A read strobe at any address other than 0x0A or 0x0B gives `rd_valid_o`=0 and `rd_data_o`=0 on the next cycle, and it leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, held while any supply is under lockout |
| last_neg_i | input | 1 | 1 if the negative supply crossed its lockout threshold last |
| evt_i | input | 8 | One-cycle event pulses, one per status bit |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read address |
| det_en_i | input | 4 | Detection-channel enable bits |
| port_req_i | input | 4 | Requested port power enables |
| rd_data_o | output | 8 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| supply_any_o | output | 1 | Summary flag for the global interrupt word |
| irq_o | output | 1 | Gated interrupt |
| port_en_o | output | 4 | Port power enables |

## Verification
A new event pulse and a clear-on-read strobe can land in the same clock cycle, and the set has to beat the clear. The bench provokes this by driving both at once. It first tests a bit that is already set and then one that was clear. The scoreboard expects the pre-clear contents in the returned data, and a following plain read must show only the bits that arrived with the clear. A second collision is an event arriving together with a plain read: the returned data must exclude that event, and the next read must include it.

// File: rtl/sevt_pkg.sv
package sevt_pkg;
  localparam int STAT_W = 8;

  // status bit positions
  localparam int B_OSC      = 7;
  localparam int B_THERM    = 6;
  localparam int B_NEG_LO   = 5;
  localparam int B_LOG_LO   = 4;
  localparam int B_AUX_LO   = 3;
  localparam int B_LOG_UV   = 2;
  localparam int B_AUX_UV   = 1;
  localparam int B_NEG_UV   = 0;

  function automatic logic [STAT_W-1:0] boot_value(input logic neg_last);
    logic [STAT_W-1:0] v;
    v = '0;
    if (neg_last) begin
      v[B_NEG_LO] = 1'b1;
      v[B_NEG_UV] = 1'b1;
    end else begin
      v[B_LOG_LO] = 1'b1;
      v[B_LOG_UV] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/sevt_store.sv
module sevt_store #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] boot_i,
  input  logic [DW-1:0] set_i,
  input  logic          clr_i,
  output logic [DW-1:0] q_o
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)
        bit_q <= boot_i[b];
      else if (set_i[b])
        bit_q <= 1'b1;
      else if (clr_i)
        bit_q <= 1'b0;
    end
    assign q_o[b] = bit_q;
  end
endmodule

// File: rtl/sevt_rdport.sv
module sevt_rdport #(
  parameter int          DW      = 8,
  parameter int          AW      = 8,
  parameter logic [7:0]  A_PLAIN = 8'h0A,
  parameter logic [7:0]  A_COR   = 8'h0B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] stat_i,
  output logic          clr_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  localparam logic [AW-1:0] PLAIN = AW'(A_PLAIN);
  localparam logic [AW-1:0] COR   = AW'(A_COR);

  logic hit_plain, hit_cor, hit;

  always_comb begin
    hit_plain = rd_i && (addr_i == PLAIN);
    hit_cor   = rd_i && (addr_i == COR);
    hit       = hit_plain || hit_cor;
    clr_o     = hit_cor;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= hit;
      rd_data_o  <= hit ? stat_i : '0;
    end
  end
endmodule

// File: rtl/sevt_irq.sv
module sevt_irq #(
  parameter int DW      = 8,
  parameter int NDET    = 4,
  parameter int OSC_BIT = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   stat_i,
  input  logic [NDET-1:0] det_en_i,
  output logic            any_o,
  output logic            irq_o
);
  logic [DW-1:0] mask;

  always_comb begin
    mask          = '1;
    mask[OSC_BIT] = |det_en_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      any_o <= |stat_i;
      irq_o <= |(stat_i & mask);
    end
  end
endmodule

// File: rtl/sevt_portgate.sv
module sevt_portgate #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] req_i,
  output logic [NPORT-1:0] en_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic en_q;
    always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b0;
      else     en_q <= req_i[p];
    end
    assign en_o[p] = en_q;
  end
endmodule

// File: rtl/supply_event_reg.sv
module supply_event_reg #(
  parameter int         AW      = 8,
  parameter int         NDET    = 4,
  parameter int         NPORT   = 4,
  parameter logic [7:0] A_PLAIN = 8'h0A,
  parameter logic [7:0] A_COR   = 8'h0B
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     last_neg_i,
  input  logic [sevt_pkg::STAT_W-1:0] evt_i,
  input  logic                     rd_i,
  input  logic [AW-1:0]            rd_addr_i,
  input  logic [NDET-1:0]          det_en_i,
  input  logic [NPORT-1:0]         port_req_i,
  output logic [sevt_pkg::STAT_W-1:0] rd_data_o,
  output logic                     rd_valid_o,
  output logic                     supply_any_o,
  output logic                     irq_o,
  output logic [NPORT-1:0]         port_en_o
);
  localparam int DW = sevt_pkg::STAT_W;

  logic [DW-1:0] stat_q;
  logic [DW-1:0] boot_val;
  logic          clr;

  assign boot_val = sevt_pkg::boot_value(last_neg_i);

  sevt_store #(.DW(DW)) u_store (
    .clk(clk), .rst(rst), .boot_i(boot_val), .set_i(evt_i),
    .clr_i(clr), .q_o(stat_q)
  );

  sevt_rdport #(.DW(DW), .AW(AW), .A_PLAIN(A_PLAIN), .A_COR(A_COR)) u_rd (
    .clk(clk), .rst(rst), .rd_i(rd_i), .addr_i(rd_addr_i), .stat_i(stat_q),
    .clr_o(clr), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  sevt_irq #(.DW(DW), .NDET(NDET), .OSC_BIT(sevt_pkg::B_OSC)) u_irq (
    .clk(clk), .rst(rst), .stat_i(stat_q), .det_en_i(det_en_i),
    .any_o(supply_any_o), .irq_o(irq_o)
  );

  sevt_portgate #(.NPORT(NPORT)) u_port (
    .clk(clk), .rst(rst), .req_i(port_req_i), .en_o(port_en_o)
  );
endmodule

// File: rtl/sevt_checker.sv
module sevt_checker #(
  parameter int AW = 8, parameter int NDET = 4, parameter int NPORT = 4,
  parameter logic [7:0] A_PLAIN = 8'h0A, parameter logic [7:0] A_COR = 8'h0B
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       evt_i,
  input logic             rd_i,
  input logic [AW-1:0]    rd_addr_i,
  input logic [NDET-1:0]  det_en_i,
  input logic [7:0]       stat_q,
  input logic [7:0]       rd_data_o,
  input logic             rd_valid_o,
  input logic             supply_any_o,
  input logic             irq_o,
  input logic [NPORT-1:0] port_en_o
);
  logic is_plain, is_cor;
  assign is_plain = rd_i && (rd_addr_i == AW'(A_PLAIN));
  assign is_cor   = rd_i && (rd_addr_i == AW'(A_COR));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !is_cor |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_plain_read_R4: assert property (@(posedge clk) disable iff (rst)
    is_plain |=> (rd_valid_o && rd_data_o == $past(stat_q)));

  assert_cor_empties_R5: assert property (@(posedge clk) disable iff (rst)
    (is_cor && evt_i == 8'h00) |=> ##1 !supply_any_o);

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (rst)
    is_cor |=> (stat_q == $past(evt_i)));

  assert_osc_gated_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_q == 8'h80 && det_en_i == '0) |=> !irq_o);

  assert_ports_off_R9: assert property (@(posedge clk)
    rst |=> (port_en_o == '0));

  assert_other_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !is_plain && !is_cor) |=> !rd_valid_o);
endmodule

bind supply_event_reg sevt_checker #(
  .AW(AW), .NDET(NDET), .NPORT(NPORT), .A_PLAIN(A_PLAIN), .A_COR(A_COR)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .rd_i(rd_i), .rd_addr_i(rd_addr_i),
  .det_en_i(det_en_i), .stat_q(stat_q), .rd_data_o(rd_data_o),
  .rd_valid_o(rd_valid_o), .supply_any_o(supply_any_o), .irq_o(irq_o),
  .port_en_o(port_en_o)
);

// File: tb/sim_supply_event_reg.sv
module sim_supply_event_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       last_neg_i = 1'b1;
  logic [7:0] evt_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] rd_addr_i = '0;
  logic [3:0] det_en_i = '0;
  logic [3:0] port_req_i = '0;
  logic [7:0] rd_data_o;
  logic       rd_valid_o, supply_any_o, irq_o;
  logic [3:0] port_en_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl = '0;
  logic [7:0] expq[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_event_reg u0 (
    .clk(clk), .rst(rst), .last_neg_i(last_neg_i), .evt_i(evt_i),
    .rd_i(rd_i), .rd_addr_i(rd_addr_i), .det_en_i(det_en_i),
    .port_req_i(port_req_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .supply_any_o(supply_any_o), .irq_o(irq_o), .port_en_o(port_en_o)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (expq.size() == 0) chk(1'b0, "R10 unexpected valid", rd_data_o, 8'h00);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(rd_data_o == e, "R4/R5/R6 read data", rd_data_o, e);
      end
    end
  end

  // driver: one cycle of stimulus, called just after a falling edge
  task automatic step(input logic [7:0] ev, input bit rd, input logic [7:0] addr);
    evt_i = ev; rd_i = rd; rd_addr_i = addr;
    @(posedge clk);
    if (rd && (addr == 8'h0A || addr == 8'h0B)) expq.push_back(mdl);
    if (rd && addr == 8'h0B) mdl = ev;
    else mdl = mdl | ev;
    @(negedge clk);
    evt_i = '0; rd_i = 1'b0; rd_addr_i = '0;
  endtask

  task automatic do_reset(input bit neg_last);
    rst = 1'b1; last_neg_i = neg_last; port_req_i = 4'hF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(port_en_o == 4'h0, "R9 ports off in reset", {4'h0, port_en_o}, 8'h00);
    rst = 1'b0;
    mdl = neg_last ? 8'h21 : 8'h14;
    expq.delete();
  endtask

  initial begin
    int n = 0;
    while (!done && n < WATCHDOG) begin @(posedge clk); n++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: negative supply last
    do_reset(1'b1);
    chk(rd_valid_o == 1'b0, "R1 no valid after reset", {7'h0, rd_valid_o}, 8'h00);
    step(8'h00, 1'b1, 8'h0A);              // R1 expect 21
    step(8'h00, 1'b0, 8'h00);
    chk(supply_any_o == 1'b1, "R7 summary set", {7'h0, supply_any_o}, 8'h01);
    // R9: ports follow request
    port_req_i = 4'h5;
    step(8'h00, 1'b0, 8'h00);
    chk(port_en_o == 4'h5, "R9 ports follow", {4'h0, port_en_o}, 8'h05);
    // R5: clear-on-read
    step(8'h00, 1'b1, 8'h0B);
    step(8'h00, 1'b0, 8'h00);
    chk(supply_any_o == 1'b0, "R5/R7 summary clear after COR", {7'h0, supply_any_o}, 8'h00);
    chk(irq_o == 1'b0, "R8 irq low when empty", {7'h0, irq_o}, 8'h00);
    // R3: sticky set, persists over idle and plain reads
    step(8'h40, 1'b0, 8'h00);
    repeat (3) step(8'h00, 1'b0, 8'h00);
    step(8'h00, 1'b1, 8'h0A);
    step(8'h00, 1'b1, 8'h0A);              // R4 unchanged
    chk(irq_o == 1'b1, "R8 irq from thermal bit", {7'h0, irq_o}, 8'h01);
    // event together with plain read: not in data, in next read
    step(8'h02, 1'b1, 8'h0A);
    step(8'h00, 1'b1, 8'h0A);
    // R6: event together with clear-on-read (set bit and new bit)
    step(8'h42, 1'b1, 8'h0B);
    step(8'h00, 1'b1, 8'h0A);              // expect 42
    step(8'h08, 1'b1, 8'h0B);
    step(8'h00, 1'b1, 8'h0A);              // expect 08
    step(8'h00, 1'b1, 8'h0B);              // empty it
    // R10: other addresses
    step(8'h00, 1'b1, 8'h0C);
    chk(rd_valid_o == 1'b0 && rd_data_o == 8'h00, "R10 no valid",
        rd_data_o, 8'h00);
    step(8'h00, 1'b1, 8'h00);
    step(8'h00, 1'b1, 8'h0A);              // still empty
    // R8: oscillator gating
    det_en_i = 4'h0;
    step(8'h80, 1'b0, 8'h00);
    step(8'h00, 1'b0, 8'h00);
    chk(irq_o == 1'b0, "R8 osc masked", {7'h0, irq_o}, 8'h00);
    chk(supply_any_o == 1'b1, "R7 summary from osc", {7'h0, supply_any_o}, 8'h01);
    det_en_i = 4'h4;
    step(8'h00, 1'b0, 8'h00);
    chk(irq_o == 1'b1, "R8 osc enabled", {7'h0, irq_o}, 8'h01);
    det_en_i = 4'h0;
    step(8'h01, 1'b0, 8'h00);
    step(8'h00, 1'b0, 8'h00);
    chk(irq_o == 1'b1, "R8 other bit unmasked", {7'h0, irq_o}, 8'h01);
    step(8'h00, 1'b1, 8'h0B);              // expect 81
    // R2: logic supply last
    do_reset(1'b0);
    step(8'h00, 1'b1, 8'h0A);              // R2 expect 14
    step(8'h00, 1'b1, 8'h0B);
    step(8'h00, 1'b1, 8'h0A);              // expect 00
    repeat (2) step(8'h00, 1'b0, 8'h00);
    chk(expq.size() == 0, "R4 scoreboard drained", 8'(expq.size()), 8'h00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule